// File: doc/BRIEF.md
# Machine Check Capture Controller

This block gathers the error strobes from the parity and check circuits of a microprogrammed CPU. Each strobe sets its own bit in a 32-bit sticky check register. The block also freezes the machine by withdrawing the enable that lets the CPU working registers load. Each strobe comes with a timing-class flag.

- An early check is seen in time to suppress the next register load, so the machine stops in the same cycle.
- A late check, such as a carry, mover-output or full-sum failure, arrives after the load of that cycle is already committed. For a late check the stop takes effect one cycle later.

Because of that extra cycle, a backup register always holds the control-store address of the previous cycle. After a late check it therefore names the microinstruction that was running when the failure happened.

A manual logout key and a channel logout request set a separate log-request bit that need not mean a real fault. Three sources clear the register and release the freeze: a check-reset button, a system-reset button and a diagnose command. Completion of an error logout also clears the register and release the freeze, and a one-cycle machine-check interrupt request follows one cycle after that clear.

Top module: `mchk_capture`

## Requirements
- R1: A high on error strobe `chk_err[i]` (i from 0 to 25) sets `chk_reg[i]` at the next clock edge. Bits 0 to 3 carry the half-sum parity checks per byte and bits 4 to 7 the full-sum parity checks per byte.
- R2: A set check bit stays set until a clear source is active. Errors that arrive while the machine is frozen are ORed into the register.
- R3: An early error (`chk_err[i]` high with `chk_late[i]` low, no clear active) raises `clk_stop` and drops `reg_ingate` in the same cycle. Both hold until a clear.
- R4: A late-only error leaves `reg_ingate` high in its detection cycle. It raises `clk_stop` from the following cycle on.
- R5: When early and late errors arrive in the same cycle, the early timing of R3 applies.
- R6: While `reg_ingate` is high, `cs_addr_bkup` loads the current `cs_addr` at each edge. While it is low, `cs_addr_bkup` holds. After a late stop, it therefore shows the address of the failing cycle.
- R7: `logout_key` or `chan_log_req` sets bit 26 of `chk_reg` and does not stop the clock.
- R8: `check_rst_pb`, `sys_rst_pb` or `diag_clr` clears `chk_reg` and the freeze at the next edge. Error and log strobes in that same cycle are dropped.
- R9: `logout_done` clears `chk_reg` and the freeze at the next edge. `mchk_irq` is high for exactly the one cycle after that cleared cycle.
- R10: Bits 27 to 31 of `chk_reg` always read zero.
- R11: While synchronous `rst` is high, the outputs are forced as follows at the next edge: `chk_reg` 0, `clk_stop` 0, `reg_ingate` 1, `cs_addr_bkup` 0 and `mchk_irq` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_err | input | 26 | Per-check error strobes |
| chk_late | input | 26 | Per-check timing class, 1 = late |
| cs_addr | input | CS_AW (12) | Current control-store address |
| logout_key | input | 1 | Manual logout key |
| chan_log_req | input | 1 | Channel logout request |
| check_rst_pb | input | 1 | Check-reset button |
| sys_rst_pb | input | 1 | System-reset button |
| diag_clr | input | 1 | Diagnose clear command |
| logout_done | input | 1 | Error logout has completed |
| chk_reg | output | 32 | Sticky check register |
| clk_stop | output | 1 | Machine clock stop |
| reg_ingate | output | 1 | Working-register load enable |
| cs_addr_bkup | output | CS_AW (12) | Previous-cycle control-store address |
| mchk_irq | output | 1 | Machine-check interrupt pulse |

## Verification
The results fall due at different times:

| Result | When it is due |
|---|---|
| `clk_stop` and `reg_ingate` for an early error | Combinationally, in the detection cycle |
| `clk_stop` for a late error | One edge later |
| Check bits and the backup address | After one edge |
| The interrupt | Two edges after `logout_done` |

The bench drives inputs on the falling edge and samples all outputs two nanoseconds later, before the next rising edge. Its reference model advances only after that sample, so each check compares the outputs against the model state of that exact cycle. The directed cases also read the outputs in the cycles just before and just after each due cycle, which catches a result that arrives one cycle early or late.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int REG_W    = 32;
    localparam int NUM_CHK  = 26;
    localparam int LOG_BIT  = 26;
    localparam int RSVD_LO  = 27;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_LATE_WAIT = 2'd1,
        ST_FROZEN    = 2'd2
    } frz_state_e;

    typedef struct packed {
        logic early_hit;
        logic late_hit;
    } chk_class_t;

    typedef struct packed {
        logic check_btn;
        logic system_btn;
        logic diagnose;
        logic logout_end;
    } clr_src_t;

    function automatic logic any_clear(input clr_src_t c);
        return c.check_btn | c.system_btn | c.diagnose | c.logout_end;
    endfunction

    function automatic chk_class_t classify(
        input logic [NUM_CHK-1:0] err,
        input logic [NUM_CHK-1:0] late,
        input logic               clr
    );
        chk_class_t r;
        r.early_hit = 1'b0;
        r.late_hit  = 1'b0;
        for (int i = 0; i < NUM_CHK; i++) begin
            if (err[i] && !late[i]) r.early_hit = 1'b1;
            if (err[i] &&  late[i]) r.late_hit  = 1'b1;
        end
        if (clr) begin
            r.early_hit = 1'b0;
            r.late_hit  = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/mcc_chk_reg.sv
module mcc_chk_reg
    import mcc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic [NUM_CHK-1:0]   err,
    input  logic                 log_req,
    output logic [REG_W-1:0]     bits
);

    for (genvar g = 0; g < REG_W; g++) begin : g_bit
        if (g < NUM_CHK) begin : g_err
            logic q;
            always_ff @(posedge clk) begin
                if (rst || clr)
                    q <= 1'b0;
                else if (err[g])
                    q <= 1'b1;
            end
            assign bits[g] = q;
        end else if (g == LOG_BIT) begin : g_log
            logic q;
            always_ff @(posedge clk) begin
                if (rst || clr)
                    q <= 1'b0;
                else if (log_req)
                    q <= 1'b1;
            end
            assign bits[g] = q;
        end else begin : g_rsvd
            assign bits[g] = 1'b0;
        end
    end

endmodule

// File: rtl/mcc_freeze_ctl.sv
module mcc_freeze_ctl
    import mcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  chk_class_t cls,
    output logic       clk_stop,
    output logic       reg_ingate
);

    frz_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = ST_RUN;
        end else begin
            unique case (st_q)
                ST_RUN: begin
                    if (cls.early_hit)
                        st_d = ST_FROZEN;
                    else if (cls.late_hit)
                        st_d = ST_LATE_WAIT;
                end
                ST_LATE_WAIT: st_d = ST_FROZEN;
                ST_FROZEN:    st_d = ST_FROZEN;
                default:      st_d = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= ST_RUN;
        else
            st_q <= st_d;
    end

    always_comb begin
        clk_stop   = (st_q != ST_RUN) || cls.early_hit;
        reg_ingate = !clk_stop;
    end

endmodule

// File: rtl/mcc_backup.sv
module mcc_backup #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_bk
);

    always_ff @(posedge clk) begin
        if (rst)
            addr_bk <= '0;
        else if (load_en)
            addr_bk <= addr_in;
    end

endmodule

// File: rtl/mcc_irq_seq.sv
module mcc_irq_seq (
    input  logic clk,
    input  logic rst,
    input  logic logout_end,
    output logic irq
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            irq     <= 1'b0;
        end else begin
            armed_q <= logout_end;
            irq     <= armed_q;
        end
    end

endmodule

// File: rtl/mchk_capture.sv
module mchk_capture
    import mcc_pkg::*;
#(
    parameter int CS_AW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CHK-1:0]   chk_err,
    input  logic [NUM_CHK-1:0]   chk_late,
    input  logic [CS_AW-1:0]     cs_addr,
    input  logic                 logout_key,
    input  logic                 chan_log_req,
    input  logic                 check_rst_pb,
    input  logic                 sys_rst_pb,
    input  logic                 diag_clr,
    input  logic                 logout_done,
    output logic [REG_W-1:0]     chk_reg,
    output logic                 clk_stop,
    output logic                 reg_ingate,
    output logic [CS_AW-1:0]     cs_addr_bkup,
    output logic                 mchk_irq
);

    clr_src_t   srcs;
    logic       clr;
    chk_class_t cls;

    always_comb begin
        srcs.check_btn  = check_rst_pb;
        srcs.system_btn = sys_rst_pb;
        srcs.diagnose   = diag_clr;
        srcs.logout_end = logout_done;
        clr             = any_clear(srcs);
        cls             = classify(chk_err, chk_late, clr);
    end

    mcc_chk_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .err     (chk_err),
        .log_req (logout_key | chan_log_req),
        .bits    (chk_reg)
    );

    mcc_freeze_ctl u_frz (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .cls        (cls),
        .clk_stop   (clk_stop),
        .reg_ingate (reg_ingate)
    );

    mcc_backup #(.AW(CS_AW)) u_bk (
        .clk     (clk),
        .rst     (rst),
        .load_en (reg_ingate),
        .addr_in (cs_addr),
        .addr_bk (cs_addr_bkup)
    );

    mcc_irq_seq u_irq (
        .clk        (clk),
        .rst        (rst),
        .logout_end (logout_done),
        .irq        (mchk_irq)
    );

endmodule

// File: rtl/mchk_capture_chk.sv
module mchk_capture_chk
    import mcc_pkg::*;
#(
    parameter int CS_AW = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_CHK-1:0]   chk_err,
    input logic [NUM_CHK-1:0]   chk_late,
    input logic [CS_AW-1:0]     cs_addr,
    input logic                 check_rst_pb,
    input logic                 sys_rst_pb,
    input logic                 diag_clr,
    input logic                 logout_done,
    input logic [REG_W-1:0]     chk_reg,
    input logic                 clk_stop,
    input logic                 reg_ingate,
    input logic [CS_AW-1:0]     cs_addr_bkup,
    input logic                 mchk_irq
);

    logic any_clr, any_early, any_late, btn_clr;
    assign btn_clr   = check_rst_pb | sys_rst_pb | diag_clr;
    assign any_clr   = btn_clr | logout_done;
    assign any_early = |(chk_err & ~chk_late);
    assign any_late  = |(chk_err & chk_late);

    assert_early_stop_R3: assert property (@(posedge clk) disable iff (rst)
        (any_early && !any_clr) |-> (clk_stop && !reg_ingate));

    assert_late_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (any_late && !any_early && !any_clr && !clk_stop) |-> reg_ingate ##1 clk_stop);

    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        !any_clr |=> ((chk_reg & $past(chk_reg)) == $past(chk_reg)));

    assert_bkup_load_R6: assert property (@(posedge clk) disable iff (rst)
        reg_ingate |=> (cs_addr_bkup == $past(cs_addr)));

    assert_bkup_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !reg_ingate |=> $stable(cs_addr_bkup));

    assert_btn_clear_R8: assert property (@(posedge clk) disable iff (rst)
        btn_clr |=> (chk_reg == '0));

    assert_logout_irq_R9: assert property (@(posedge clk) disable iff (rst)
        logout_done |=> (chk_reg == '0) ##1 mchk_irq);

    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (rst)
        chk_reg[REG_W-1:RSVD_LO] == '0);

endmodule

bind mchk_capture mchk_capture_chk #(.CS_AW(CS_AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .chk_err      (chk_err),
    .chk_late     (chk_late),
    .cs_addr      (cs_addr),
    .check_rst_pb (check_rst_pb),
    .sys_rst_pb   (sys_rst_pb),
    .diag_clr     (diag_clr),
    .logout_done  (logout_done),
    .chk_reg      (chk_reg),
    .clk_stop     (clk_stop),
    .reg_ingate   (reg_ingate),
    .cs_addr_bkup (cs_addr_bkup),
    .mchk_irq     (mchk_irq)
);

// File: tb/tb_mchk_capture.sv
`timescale 1ns/1ps
module tb_mchk_capture;

    localparam int AW = 12;
    localparam int NC = 26;

    logic          clk = 1'b0;
    logic          rst;
    logic [NC-1:0] chk_err, chk_late;
    logic [AW-1:0] cs_addr;
    logic          logout_key, chan_log_req, check_rst_pb, sys_rst_pb, diag_clr, logout_done;
    logic [31:0]   chk_reg;
    logic          clk_stop, reg_ingate, mchk_irq;
    logic [AW-1:0] cs_addr_bkup;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model state
    logic [31:0]   m_chk;
    int            m_st;      // 0 run, 1 late wait, 2 frozen
    logic [AW-1:0] m_bk;
    logic          m_irq1, m_irq2;

    always #5 clk = ~clk;

    mchk_capture #(.CS_AW(AW)) dut (
        .clk(clk), .rst(rst), .chk_err(chk_err), .chk_late(chk_late), .cs_addr(cs_addr),
        .logout_key(logout_key), .chan_log_req(chan_log_req), .check_rst_pb(check_rst_pb),
        .sys_rst_pb(sys_rst_pb), .diag_clr(diag_clr), .logout_done(logout_done),
        .chk_reg(chk_reg), .clk_stop(clk_stop), .reg_ingate(reg_ingate),
        .cs_addr_bkup(cs_addr_bkup), .mchk_irq(mchk_irq)
    );

    function automatic logic f_clr();
        return check_rst_pb | sys_rst_pb | diag_clr | logout_done;
    endfunction

    function automatic logic f_exp_stop();
        return (m_st != 0) || (!f_clr() && |(chk_err & ~chk_late));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_compare();
        chk("R1 R2 R7 R8 R9 R10 chk_reg", chk_reg, m_chk);
        chk("R3 R4 R5 clk_stop", {31'd0, clk_stop}, {31'd0, f_exp_stop()});
        chk("R3 R4 reg_ingate", {31'd0, reg_ingate}, {31'd0, !f_exp_stop()});
        chk("R6 cs_addr_bkup", {20'd0, cs_addr_bkup}, {20'd0, m_bk});
        chk("R9 mchk_irq", {31'd0, mchk_irq}, {31'd0, m_irq2});
    endtask

    task automatic model_update();
        logic stop;
        stop = f_exp_stop();
        if (rst) begin
            m_chk = '0; m_st = 0; m_bk = '0; m_irq1 = 1'b0; m_irq2 = 1'b0;
        end else begin
            if (!stop) m_bk = cs_addr;
            m_irq2 = m_irq1;
            m_irq1 = logout_done;
            if (f_clr()) begin
                m_chk = '0;
                m_st  = 0;
            end else begin
                m_chk = m_chk | {6'd0, (logout_key | chan_log_req), chk_err};
                if (m_st == 1)
                    m_st = 2;
                else if (m_st == 0) begin
                    if (|(chk_err & ~chk_late)) m_st = 2;
                    else if (|(chk_err & chk_late)) m_st = 1;
                end
            end
        end
    endtask

    task automatic settle();
        #2;
        if (!rst) model_compare();
    endtask

    task automatic advance();
        model_update();
        @(posedge clk);
        @(negedge clk);
        cs_addr = cs_addr + 12'd1;
    endtask

    task automatic idle_inputs();
        chk_err = '0; chk_late = '0;
        logout_key = 0; chan_log_req = 0;
        check_rst_pb = 0; sys_rst_pb = 0; diag_clr = 0; logout_done = 0;
    endtask

    task automatic cyc();
        settle();
        advance();
        idle_inputs();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] r;
        void'($urandom(32'd2024));
        idle_inputs();
        cs_addr = 12'h100;
        rst = 1'b1;
        m_chk = '0; m_st = 0; m_bk = '0; m_irq1 = 0; m_irq2 = 0;
        @(negedge clk);
        repeat (3) begin
            settle();
            advance();
        end
        rst = 1'b0;
        // R11 reset state
        #2;
        chk("R11 chk_reg", chk_reg, 32'd0);
        chk("R11 clk_stop", {31'd0, clk_stop}, 32'd0);
        chk("R11 reg_ingate", {31'd0, reg_ingate}, 32'd1);
        chk("R11 mchk_irq", {31'd0, mchk_irq}, 32'd0);
        chk("R11 cs_addr_bkup", {20'd0, cs_addr_bkup}, 32'd0);
        advance();

        // R3 early check stops in the same cycle
        chk_err[2] = 1'b1;
        settle();
        chk("R3 early stop", {30'd0, clk_stop, reg_ingate}, 32'd2);
        advance(); idle_inputs();
        settle();
        chk("R1 bit2 set", chk_reg, 32'h4);
        chk("R3 stop held", {31'd0, clk_stop}, 32'd1);
        advance();
        // R2 additional error while frozen ORs in
        chk_err[9] = 1'b1; chk_late[9] = 1'b1;
        cyc();
        settle();
        chk("R2 or while frozen", chk_reg, 32'h204);
        advance();
        // R8 check-reset clears and drops same-cycle error
        check_rst_pb = 1'b1; chk_err[11] = 1'b1;
        cyc();
        settle();
        chk("R8 cleared", chk_reg, 32'd0);
        chk("R8 released", {31'd0, clk_stop}, 32'd0);
        advance();

        // R4 / R6 late check
        cs_addr = 12'h123;
        chk_err[5] = 1'b1; chk_late[5] = 1'b1;
        settle();
        chk("R4 no stop in detect cycle", {30'd0, clk_stop, reg_ingate}, 32'd1);
        advance(); idle_inputs();
        settle();
        chk("R4 stop next cycle", {31'd0, clk_stop}, 32'd1);
        chk("R6 backup holds failing addr", {20'd0, cs_addr_bkup}, 32'h123);
        advance();
        settle();
        chk("R6 backup frozen", {20'd0, cs_addr_bkup}, 32'h123);
        advance();
        sys_rst_pb = 1'b1;
        cyc();

        // R5 early and late together
        chk_err[0] = 1'b1; chk_err[8] = 1'b1; chk_late[8] = 1'b1;
        settle();
        chk("R5 early timing wins", {31'd0, clk_stop}, 32'd1);
        advance(); idle_inputs();
        diag_clr = 1'b1;
        cyc();

        // R7 log request bit
        logout_key = 1'b1;
        cyc();
        settle();
        chk("R7 key sets bit26", chk_reg, 32'h0400_0000);
        chk("R7 no stop", {31'd0, clk_stop}, 32'd0);
        advance();
        check_rst_pb = 1'b1;
        cyc();
        chan_log_req = 1'b1;
        cyc();
        settle();
        chk("R7 channel sets bit26", chk_reg, 32'h0400_0000);
        advance();

        // R9 logout completion
        chk_err[3] = 1'b1;
        cyc();
        logout_done = 1'b1;
        cyc();
        settle();
        chk("R9 cleared", chk_reg, 32'd0);
        chk("R9 irq not yet", {31'd0, mchk_irq}, 32'd0);
        advance();
        settle();
        chk("R9 irq pulse", {31'd0, mchk_irq}, 32'd1);
        advance();
        settle();
        chk("R9 irq single", {31'd0, mchk_irq}, 32'd0);
        advance();

        // R10 all sources set
        chk_err = '1; logout_key = 1'b1;
        cyc();
        settle();
        chk("R10 reserved zero", chk_reg, 32'h07FF_FFFF);
        advance();
        sys_rst_pb = 1'b1;
        cyc();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            r = $urandom;
            if (r[3:0] == 4'd0) begin
                chk_err[$urandom % NC] = 1'b1;
                chk_late = NC'($urandom);
            end
            if (r[9:4] == 6'd1) check_rst_pb = 1'b1;
            if (r[9:4] == 6'd2) sys_rst_pb   = 1'b1;
            if (r[9:4] == 6'd3) diag_clr     = 1'b1;
            if (r[9:4] == 6'd4) logout_done  = 1'b1;
            if (r[15:10] == 6'd5) logout_key   = 1'b1;
            if (r[15:10] == 6'd6) chan_log_req = 1'b1;
            cyc();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule